// File: doc/BRIEF.md
# Motion Compensation Reference Area Fetcher

This block turns one motion-compensation request into the memory windows needed to interpolate a partition from a reference frame. A request gives the partition's top-left pixel position, its width and height (4 to 16 pixels), a motion vector in quarter-pixel units for each axis, and a reference index. For each request the block hands out three window descriptors, one per plane, in the order luma, blue-difference chroma, red-difference chroma. Each descriptor carries a start row, a start column, a width, a height, the plane, the reference index and a flag that says a frame border cut the window.

In any axis where the vector has a fractional part, the window grows by the margin the interpolation filter reads: two samples before the partition and three after. The chroma planes have half the luma resolution, so the partition position and size are halved. The same vector is read in eighth-sample units of the chroma plane. Every window is clipped to the frame of its plane. Chroma windows are then widened to whole 16-byte column blocks so that the transfer engine can move them in aligned units. Descriptors leave through a valid/ready handshake. A new request is taken only when no descriptor is pending.

Top module: `mc_ref_fetch`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1 and `desc_valid` is 0.
- R2: An accepted request produces exactly three descriptors, with `desc_plane` 0 (luma), then 1 (Cb), then 2 (Cr). `req_ready` stays 0 while any of them is pending, and a request offered during that time is ignored.
- R3: Luma window along one axis: the start is position + (vector arithmetically shifted right by 2) and the length is the partition size. If the low 2 vector bits are nonzero, the start drops by 2 and the length grows by 5. The largest window is therefore 21 by 21.
- R4: Chroma window along one axis: position and size are halved. The integer offset is the vector arithmetically shifted right by 3, and the low 3 vector bits are the fraction. The margin rule of R3 applies when that fraction is nonzero.
- R5: Both window ends are clipped to [0, plane dimension − 1], where the chroma plane dimension is half the luma one. Width and height are measured between the clipped ends. `desc_clamped` is 1 exactly when some end moved.
- R6: For chroma planes, the clipped start column is rounded down to a multiple of 16 and the clipped end column is rounded up to the last column of its 16-column block. Chroma rows and all luma coordinates are not rounded.
- R7: `desc_ref` equals the reference index of the accepted request on all three descriptors.
- R8: While `desc_valid` is 1 and `desc_ready` is 0, every descriptor output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_px | input | 11 | Partition left column, luma pixels |
| req_py | input | 11 | Partition top row, luma pixels |
| req_w | input | 5 | Partition width, 4..16 |
| req_h | input | 5 | Partition height, 4..16 |
| req_mvx | input | 14 | Horizontal vector, signed quarter-pixel |
| req_mvy | input | 14 | Vertical vector, signed quarter-pixel |
| req_ref | input | 4 | Reference frame index |
| desc_valid | output | 1 | Descriptor offered |
| desc_ready | input | 1 | Descriptor taken |
| desc_plane | output | 2 | 0 luma, 1 Cb, 2 Cr |
| desc_col | output | 11 | Window start column (bytes) |
| desc_row | output | 11 | Window start row |
| desc_w | output | 6 | Window width |
| desc_h | output | 6 | Window height |
| desc_ref | output | 4 | Reference index |
| desc_clamped | output | 1 | A frame border cut the window |

## Verification
Some properties are checked on every cycle. These are the luma, Cb, Cr ordering, the blocking of new requests while descriptors are pending, and the holding of outputs under backpressure. They also cover the 16-column alignment of chroma windows, the fit of each window inside its plane, and the 21-sample upper bound on luma windows. Other behaviour can only be shown by scenarios with known answers. This covers the exact window arithmetic for integer, fractional and negative vectors, and the halving and eighth-sample reading of the vector for chroma. It also covers the clamped flag at the top-left and bottom-right corners and the case where a chroma window straddles two 16-column blocks.

// File: rtl/mcf_pkg.sv
// Shared definitions for the reference area fetcher.
// Assumes 4:2:0 chroma subsampling and a six-tap interpolation margin.
package mcf_pkg;
    typedef enum logic [1:0] {
        PLANE_Y  = 2'd0,
        PLANE_CB = 2'd1,
        PLANE_CR = 2'd2
    } plane_t;

    localparam int MARGIN_PRE  = 2;
    localparam int MARGIN_POST = 3;
    localparam int MARGIN_ALL  = MARGIN_PRE + MARGIN_POST;
endpackage

// File: rtl/mcf_axis_window.sv
// One axis of a fetch window: offset by the vector, add the filter margin
// when the fraction is nonzero, clip to the plane and optionally align.
// Assumes DIM is a multiple of 2*(1<<ALIGN_LG) so aligned ends stay in frame.
module mcf_axis_window #(
    parameter int COORD_W  = 11,
    parameter int MV_W     = 14,
    parameter int SIZE_W   = 5,
    parameter int LEN_W    = 6,
    parameter int DIM      = 1920,
    parameter int ALIGN_LG = 4
) (
    input  logic [COORD_W-1:0]      pos,
    input  logic [SIZE_W-1:0]       size,
    input  logic signed [MV_W-1:0]  mv,
    input  logic                    chroma,
    input  logic                    align_en,
    output logic [COORD_W-1:0]      start,
    output logic [LEN_W-1:0]        len,
    output logic                    clamped
);
    import mcf_pkg::*;

    localparam int IW = COORD_W + 3;

    logic signed [IW-1:0] mv_int, p, s, lo, hi, lim, lo_c, hi_c, lo_a, hi_a, span;
    logic [2:0] frac;
    logic       sub;

    // Scale the request to the plane and form the unclipped window ends.
    always_comb begin
        mv_int = chroma ? IW'(mv >>> 3) : IW'(mv >>> 2);
        frac   = chroma ? mv[2:0] : {1'b0, mv[1:0]};
        p      = chroma ? IW'(pos >> 1) : IW'(pos);
        s      = chroma ? IW'(size >> 1) : IW'(size);
        sub    = (frac != 3'd0);
        lo     = p + mv_int - (sub ? IW'(MARGIN_PRE) : IW'(0));
        hi     = lo + s - IW'(1) + (sub ? IW'(MARGIN_ALL) : IW'(0));
        lim    = chroma ? IW'(DIM / 2 - 1) : IW'(DIM - 1);
    end

    // Clip both ends to the plane, then widen to aligned blocks if asked.
    always_comb begin
        lo_c = (lo < 0) ? '0 : ((lo > lim) ? lim : lo);
        hi_c = (hi < 0) ? '0 : ((hi > lim) ? lim : hi);
        if (align_en) begin
            lo_a = {lo_c[IW-1:ALIGN_LG], {ALIGN_LG{1'b0}}};
            hi_a = {hi_c[IW-1:ALIGN_LG], {ALIGN_LG{1'b1}}};
        end else begin
            lo_a = lo_c;
            hi_a = hi_c;
        end
        span    = hi_a - lo_a + IW'(1);
        start   = lo_a[COORD_W-1:0];
        len     = span[LEN_W-1:0];
        clamped = (lo != lo_c) || (hi != hi_c);
    end
endmodule

// File: rtl/mcf_seq.sv
// Request acceptance and the per-request walk through the three planes.
// Assumes the request fields are captured by the parent on load.
module mcf_seq (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    output logic            load,
    output logic            desc_valid,
    input  logic            desc_ready,
    output mcf_pkg::plane_t plane
);
    import mcf_pkg::*;

    logic busy;

    assign req_ready  = !busy;
    assign load       = !busy && req_valid;
    assign desc_valid = busy;

    // Take a request when idle, then advance Y, Cb, Cr on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            plane <= PLANE_Y;
        end else if (load) begin
            busy  <= 1'b1;
            plane <= PLANE_Y;
        end else if (busy && desc_ready) begin
            if (plane == PLANE_CR) begin
                busy <= 1'b0;
            end else begin
                plane <= plane_t'(plane + 2'd1);
            end
        end
    end

    AST_PENDING_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> !req_ready); // R2
    AST_Y_THEN_CB: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_ready && plane == PLANE_Y) |=> (desc_valid && plane == PLANE_CB)); // R2
    AST_CB_THEN_CR: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_ready && plane == PLANE_CB) |=> (desc_valid && plane == PLANE_CR)); // R2
endmodule

// File: rtl/mc_ref_fetch.sv
// Motion compensation reference area fetcher: captures one request and
// emits luma, Cb and Cr fetch windows through a valid/ready handshake.
// Assumes FRAME_W and FRAME_H are multiples of 32 and partitions of 4..16.
module mc_ref_fetch #(
    parameter int FRAME_W  = 1920,
    parameter int FRAME_H  = 1088,
    parameter int COORD_W  = 11,
    parameter int MV_W     = 14,
    parameter int SIZE_W   = 5,
    parameter int LEN_W    = 6,
    parameter int REF_W    = 4,
    parameter int ALIGN_LG = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [COORD_W-1:0]     req_px,
    input  logic [COORD_W-1:0]     req_py,
    input  logic [SIZE_W-1:0]      req_w,
    input  logic [SIZE_W-1:0]      req_h,
    input  logic signed [MV_W-1:0] req_mvx,
    input  logic signed [MV_W-1:0] req_mvy,
    input  logic [REF_W-1:0]       req_ref,
    output logic                   desc_valid,
    input  logic                   desc_ready,
    output logic [1:0]             desc_plane,
    output logic [COORD_W-1:0]     desc_col,
    output logic [COORD_W-1:0]     desc_row,
    output logic [LEN_W-1:0]       desc_w,
    output logic [LEN_W-1:0]       desc_h,
    output logic [REF_W-1:0]       desc_ref,
    output logic                   desc_clamped
);
    import mcf_pkg::*;

    localparam int MAX_LUMA = 16 + MARGIN_ALL;

    plane_t                  plane;
    logic                    load, chroma, clamp_x, clamp_y;
    logic [COORD_W-1:0]      r_px, r_py;
    logic [SIZE_W-1:0]       r_w, r_h;
    logic signed [MV_W-1:0]  r_mvx, r_mvy;
    logic [REF_W-1:0]        r_ref;

    mcf_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .load       (load),
        .desc_valid (desc_valid),
        .desc_ready (desc_ready),
        .plane      (plane)
    );

    // Capture the request fields when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_px  <= '0;
            r_py  <= '0;
            r_w   <= '0;
            r_h   <= '0;
            r_mvx <= '0;
            r_mvy <= '0;
            r_ref <= '0;
        end else if (load) begin
            r_px  <= req_px;
            r_py  <= req_py;
            r_w   <= req_w;
            r_h   <= req_h;
            r_mvx <= req_mvx;
            r_mvy <= req_mvy;
            r_ref <= req_ref;
        end
    end

    assign chroma = (plane != PLANE_Y);

    mcf_axis_window #(
        .COORD_W (COORD_W), .MV_W (MV_W), .SIZE_W (SIZE_W),
        .LEN_W (LEN_W), .DIM (FRAME_W), .ALIGN_LG (ALIGN_LG)
    ) u_xwin (
        .pos (r_px), .size (r_w), .mv (r_mvx), .chroma (chroma),
        .align_en (chroma), .start (desc_col), .len (desc_w), .clamped (clamp_x)
    );

    mcf_axis_window #(
        .COORD_W (COORD_W), .MV_W (MV_W), .SIZE_W (SIZE_W),
        .LEN_W (LEN_W), .DIM (FRAME_H), .ALIGN_LG (ALIGN_LG)
    ) u_ywin (
        .pos (r_py), .size (r_h), .mv (r_mvy), .chroma (chroma),
        .align_en (1'b0), .start (desc_row), .len (desc_h), .clamped (clamp_y)
    );

    assign desc_plane   = plane;
    assign desc_ref     = r_ref;
    assign desc_clamped = clamp_x || clamp_y;

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_plane) && $stable(desc_col)
            && $stable(desc_row) && $stable(desc_w) && $stable(desc_h) && $stable(desc_ref))); // R8
    AST_CHROMA_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && chroma) |-> (desc_col[ALIGN_LG-1:0] == '0 && desc_w[ALIGN_LG-1:0] == '0)); // R6
    AST_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> ((int'(desc_col) + int'(desc_w) <= (chroma ? FRAME_W / 2 : FRAME_W))
            && (int'(desc_row) + int'(desc_h) <= (chroma ? FRAME_H / 2 : FRAME_H)))); // R5
    AST_LUMA_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !chroma) |-> (desc_w != '0 && desc_h != '0
            && int'(desc_w) <= MAX_LUMA && int'(desc_h) <= MAX_LUMA)); // R3
endmodule

// File: tb/mc_ref_fetch_tb.sv
module mc_ref_fetch_tb;
    localparam int NV = 5;
    // px, py, w, h, mvx, mvy
    localparam int STIM [NV][6] = '{
        '{64, 32, 16, 16, 8, -4},
        '{100, 200, 8, 4, 5, 6},
        '{0, 0, 4, 4, -3, -8},
        '{1912, 1080, 8, 8, 16, 13},
        '{60, 0, 16, 16, 0, 0}
    };
    // [luma, chroma] x {col, row, w, h, clamped}
    localparam int EXPV [NV][2][5] = '{
        '{'{66, 31, 16, 16, 0}, '{32, 13, 16, 13, 0}},
        '{'{99, 199, 13, 9, 0}, '{48, 98, 16, 7, 0}},
        '{'{0, 0, 6, 2, 1},     '{0, 0, 16, 1, 1}},
        '{'{1916, 1081, 4, 7, 1}, '{944, 539, 16, 5, 1}},
        '{'{60, 0, 16, 16, 0},  '{16, 0, 32, 8, 0}}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [10:0] req_px = '0, req_py = '0;
    logic [4:0] req_w = '0, req_h = '0;
    logic signed [13:0] req_mvx = '0, req_mvy = '0;
    logic [3:0] req_ref = '0;
    logic desc_valid;
    logic desc_ready = 1'b0;
    logic [1:0] desc_plane;
    logic [10:0] desc_col, desc_row;
    logic [5:0] desc_w, desc_h;
    logic [3:0] desc_ref;
    logic desc_clamped;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mc_ref_fetch u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_px (req_px), .req_py (req_py), .req_w (req_w), .req_h (req_h),
        .req_mvx (req_mvx), .req_mvy (req_mvy), .req_ref (req_ref),
        .desc_valid (desc_valid), .desc_ready (desc_ready),
        .desc_plane (desc_plane), .desc_col (desc_col), .desc_row (desc_row),
        .desc_w (desc_w), .desc_h (desc_h), .desc_ref (desc_ref),
        .desc_clamped (desc_clamped)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input int v, input int rf);
        req_px  = 11'(STIM[v][0]);
        req_py  = 11'(STIM[v][1]);
        req_w   = 5'(STIM[v][2]);
        req_h   = 5'(STIM[v][3]);
        req_mvx = 14'(STIM[v][4]);
        req_mvy = 14'(STIM[v][5]);
        req_ref = 4'(rf);
    endtask

    // Check one descriptor against vector v (at a negedge).
    task automatic chk_desc(input int v, input int pl, input int rf);
        int k = (pl == 0) ? 0 : 1;
        chk("R2 valid", int'(desc_valid), 1);
        chk("R2 plane order", int'(desc_plane), pl);
        chk(k ? "R4/R6 chroma col" : "R3 luma col", int'(desc_col), EXPV[v][k][0]);
        chk(k ? "R4 chroma row" : "R3 luma row", int'(desc_row), EXPV[v][k][1]);
        chk(k ? "R4/R6 chroma width" : "R3 luma width", int'(desc_w), EXPV[v][k][2]);
        chk(k ? "R4 chroma height" : "R3 luma height", int'(desc_h), EXPV[v][k][3]);
        chk("R5 clamped flag", int'(desc_clamped), EXPV[v][k][4]);
        chk("R7 ref index", int'(desc_ref), rf);
    endtask

    task automatic run_vec(input int v, input int rf);
        @(negedge clk);
        chk("R2 ready when idle", int'(req_ready), 1);
        drive(v, rf);
        req_valid = 1'b1;
        desc_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int pl = 0; pl < 3; pl++) begin
            chk_desc(v, pl, rf);
            if (pl < 2) @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready after reset", int'(req_ready), 1);
        chk("R1 valid after reset", int'(desc_valid), 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            run_vec(v, v + 3);
        end
        @(negedge clk);
        desc_ready = 1'b0;
        chk("R2 no extra descriptor", int'(desc_valid), 0);

        // R8 and R2: stall on luma while another request is offered
        drive(1, 9);
        req_valid = 1'b1;
        @(negedge clk);
        drive(0, 2);
        for (int i = 0; i < 3; i++) begin
            chk("R8 stall plane", int'(desc_plane), 0);
            chk("R8 stall col", int'(desc_col), EXPV[1][0][0]);
            chk("R2 ready low while pending", int'(req_ready), 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        desc_ready = 1'b1;
        for (int pl = 0; pl < 3; pl++) begin
            chk_desc(1, pl, 9);
            @(negedge clk);
        end
        chk("R2 offered request ignored", int'(desc_valid), 0);
        chk("R2 ready again", int'(req_ready), 1);

        // R1 reset during activity clears the pending descriptors
        drive(2, 5);
        req_valid = 1'b1;
        desc_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 valid cleared by reset", int'(desc_valid), 0);
        chk("R1 ready set by reset", int'(req_ready), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule